// File: doc/BRIEF.md
# Full-duplex nibble data interface

This block moves 10-bit sample words across two narrow 6-bit buses that run at twice the word rate. On the transmit side it takes nibbles from a digital back end, finds the first nibble of each word by the level of a framing strobe, and rebuilds the parallel word for the converter-side logic. On the receive side it takes converter words and drives each one out as two nibbles, with a framing strobe of its own that marks the first.

Configuration pins choose three things. The first is the strobe level that marks a first nibble. The second is whether the bus carries two's complement or straight binary. The third is whether the transmit bus carries data, gain words or a loop-back echo. The rebuilt transmit word has no back-pressure: it is a one-cycle valid pulse that the consumer must take. The receive word input uses valid/ready, and a word moves on a clock edge where both are high.

Top module: `nibif_top`

## Requirements
- R1: A transmit nibble with `tx_sync` equal to `cfg_first_lvl` supplies word bits [9:5] from its bits [4:0]. The nibble on the next clock, with the opposite strobe level, supplies bits [4:0]. Nibble bit 5 is ignored. `tx_word_valid` is high for exactly one cycle, in the cycle after the edge that samples the second nibble.
- R2: `cfg_first_lvl` sets the strobe level that marks a first nibble, on both the transmit bus and the receive bus.
- R3: With `cfg_offset_bin` = 1, the word MSB (bit 9) is inverted between bus format and word format, in both directions. With 0, words pass through unchanged as two's complement.
- R4: A receive word accepted at an edge drives `rx_nib` = {0, word[9:5]} with `rx_sync` = `cfg_first_lvl` in the next cycle, then {0, word[4:0]} with the opposite strobe level in the cycle after that.
- R5: `rx_word_ready` is low in the cycle after an accepted word, and low while loop-back is on. Otherwise it is high.
- R6: When no receive word is pending, `rx_nib` is 0 and `rx_sync` is the inverse of `cfg_first_lvl`.
- R7: A second-level transmit nibble with no first nibble before it is ignored and produces no word. A new first nibble replaces an earlier one that is still waiting for its second nibble.
- R8: With `cfg_loopback` = 1, `rx_nib` and `rx_sync` repeat `tx_nib` and `tx_sync` one clock later.
- R9: With `cfg_gain_mode` = 1, a transmit nibble at the first-nibble level loads all 6 bits into `gain_word`, which shows the new value in the next cycle. No transmit word is produced in this mode.
- R10: After reset, `tx_word_valid` = 0, `rx_nib` = 0, `rx_sync` = 0, `gain_word` = 0 and `rx_word_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, twice the word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_first_lvl | input | 1 | Strobe level that marks a first nibble |
| cfg_offset_bin | input | 1 | 1 selects straight binary on the buses |
| cfg_loopback | input | 1 | Echo the transmit bus onto the receive bus |
| cfg_gain_mode | input | 1 | Transmit bus carries gain words |
| tx_nib | input | 6 | Transmit nibble bus |
| tx_sync | input | 1 | Transmit framing strobe |
| tx_word | output | 10 | Rebuilt transmit word, two's complement |
| tx_word_valid | output | 1 | One-cycle pulse that qualifies tx_word |
| gain_word | output | 6 | Receive gain register |
| rx_word | input | 10 | Converter word, two's complement |
| rx_word_valid | input | 1 | rx_word is offered |
| rx_word_ready | output | 1 | Block can accept rx_word |
| rx_nib | output | 6 | Receive nibble bus |
| rx_sync | output | 1 | Receive framing strobe |

## Verification
Every result is due one clock after its cause, and every check waits for that edge. A rebuilt word appears one cycle after the second nibble is sampled. A gain load and a loop-back echo show one cycle after the nibble. The first receive nibble appears one cycle after acceptance, and the second nibble one cycle after that. The bench drives inputs on falling edges. It samples outputs on the falling edge that follows the rising edge where each result is due. That way no check depends on the order of processes at a clock edge.

// File: rtl/nibif_pkg.sv
package nibif_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned NIB_W  = 6;
  typedef enum logic {SER_IDLE, SER_LOW} ser_state_e;
endpackage

// File: rtl/nibif_fmt.sv
module nibif_fmt #(
  parameter int unsigned W = 10
) (
  input  logic [W-1:0] din,
  input  logic         flip_msb,
  output logic [W-1:0] dout
);
  always_comb begin
    dout = din;
    dout[W-1] = din[W-1] ^ flip_msb;
  end
endmodule

// File: rtl/nibif_tx_deframe.sv
module nibif_tx_deframe #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned NIB_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib,
  input  logic              sync,
  input  logic              first_lvl,
  input  logic              offset_bin,
  input  logic              gain_mode,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic [NIB_W-1:0]  gain
);
  localparam int unsigned HALF = WORD_W / 2;

  logic [HALF-1:0]   hi_q;
  logic              have_hi_q;
  logic [WORD_W-1:0] bus_word;
  logic [WORD_W-1:0] conv_word;
  logic              is_first;

  assign is_first = (sync == first_lvl);
  assign bus_word = {hi_q, nib[HALF-1:0]};

  nibif_fmt #(.W(WORD_W)) u_fmt (
    .din(bus_word), .flip_msb(offset_bin), .dout(conv_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      have_hi_q <= 1'b0;
      word      <= '0;
      valid     <= 1'b0;
      gain      <= '0;
    end else begin
      valid <= 1'b0;
      if (gain_mode) begin
        have_hi_q <= 1'b0;
        if (is_first) gain <= nib;
      end else if (is_first) begin
        hi_q      <= nib[HALF-1:0];
        have_hi_q <= 1'b1;
      end else if (have_hi_q) begin
        word      <= conv_word;
        valid     <= 1'b1;
        have_hi_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nibif_rx_frame.sv
module nibif_rx_frame
  import nibif_pkg::*;
#(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned NIB_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic              hold,
  input  logic              first_lvl,
  input  logic              offset_bin,
  output logic [NIB_W-1:0]  nib,
  output logic              sync
);
  localparam int unsigned HALF = WORD_W / 2;
  localparam int unsigned PAD  = NIB_W - HALF;

  ser_state_e        state_q;
  logic [HALF-1:0]   lo_q;
  logic [WORD_W-1:0] bus_word;

  nibif_fmt #(.W(WORD_W)) u_fmt (
    .din(word), .flip_msb(offset_bin), .dout(bus_word)
  );

  assign word_ready = (state_q == SER_IDLE) && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      lo_q    <= '0;
      nib     <= '0;
      sync    <= 1'b0;
    end else if (word_valid && word_ready) begin
      lo_q    <= bus_word[HALF-1:0];
      nib     <= {{PAD{1'b0}}, bus_word[WORD_W-1:HALF]};
      sync    <= first_lvl;
      state_q <= SER_LOW;
    end else if (state_q == SER_LOW) begin
      nib     <= {{PAD{1'b0}}, lo_q};
      sync    <= ~first_lvl;
      state_q <= SER_IDLE;
    end else begin
      nib     <= '0;
      sync    <= ~first_lvl;
    end
  end
endmodule

// File: rtl/nibif_top.sv
module nibif_top #(
  parameter int unsigned WORD_W = nibif_pkg::WORD_W,
  parameter int unsigned NIB_W  = nibif_pkg::NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_first_lvl,
  input  logic              cfg_offset_bin,
  input  logic              cfg_loopback,
  input  logic              cfg_gain_mode,
  input  logic [NIB_W-1:0]  tx_nib,
  input  logic              tx_sync,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_word_valid,
  output logic [NIB_W-1:0]  gain_word,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_word_valid,
  output logic              rx_word_ready,
  output logic [NIB_W-1:0]  rx_nib,
  output logic              rx_sync
);
  logic [NIB_W-1:0] frm_nib;
  logic             frm_sync;
  logic [NIB_W-1:0] loop_nib_q;
  logic             loop_sync_q;
  logic             loop_sel_q;

  nibif_tx_deframe #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_txd (
    .clk(clk), .rst_n(rst_n), .nib(tx_nib), .sync(tx_sync),
    .first_lvl(cfg_first_lvl), .offset_bin(cfg_offset_bin),
    .gain_mode(cfg_gain_mode), .word(tx_word), .valid(tx_word_valid),
    .gain(gain_word)
  );

  nibif_rx_frame #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_rxf (
    .clk(clk), .rst_n(rst_n), .word(rx_word), .word_valid(rx_word_valid),
    .word_ready(rx_word_ready), .hold(cfg_loopback),
    .first_lvl(cfg_first_lvl), .offset_bin(cfg_offset_bin),
    .nib(frm_nib), .sync(frm_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_nib_q  <= '0;
      loop_sync_q <= 1'b0;
      loop_sel_q  <= 1'b0;
    end else begin
      loop_nib_q  <= tx_nib;
      loop_sync_q <= tx_sync;
      loop_sel_q  <= cfg_loopback;
    end
  end

  assign rx_nib  = loop_sel_q ? loop_nib_q  : frm_nib;
  assign rx_sync = loop_sel_q ? loop_sync_q : frm_sync;
endmodule

// File: rtl/nibif_checker.sv
module nibif_checker #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned NIB_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_first_lvl,
  input logic              cfg_loopback,
  input logic              cfg_gain_mode,
  input logic [NIB_W-1:0]  tx_nib,
  input logic              tx_sync,
  input logic              tx_word_valid,
  input logic [NIB_W-1:0]  gain_word,
  input logic              rx_word_valid,
  input logic              rx_word_ready,
  input logic [NIB_W-1:0]  rx_nib,
  input logic              rx_sync
);
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_valid |=> !tx_word_valid);

  p_first_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_valid && rx_word_ready && !cfg_loopback) |=>
      (rx_sync == $past(cfg_first_lvl)) && !rx_nib[NIB_W-1]);

  p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word_valid && rx_word_ready) |=> !rx_word_ready);

  p_loop_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loopback |-> !rx_word_ready);

  p_loop_echo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loopback |=> (rx_nib == $past(tx_nib)) && (rx_sync == $past(tx_sync)));

  p_gain_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gain_mode && (tx_sync == cfg_first_lvl)) |=> gain_word == $past(tx_nib));

  p_gain_no_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_gain_mode |=> !tx_word_valid);
endmodule

bind nibif_top nibif_checker #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_nibif_checker (
  .clk(clk), .rst_n(rst_n), .cfg_first_lvl(cfg_first_lvl),
  .cfg_loopback(cfg_loopback), .cfg_gain_mode(cfg_gain_mode),
  .tx_nib(tx_nib), .tx_sync(tx_sync), .tx_word_valid(tx_word_valid),
  .gain_word(gain_word), .rx_word_valid(rx_word_valid),
  .rx_word_ready(rx_word_ready), .rx_nib(rx_nib), .rx_sync(rx_sync)
);

// File: tb/nibif_top_bench.sv
module nibif_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_first_lvl = 1'b1, cfg_offset_bin = 1'b0;
  logic       cfg_loopback = 1'b0, cfg_gain_mode = 1'b0;
  logic [5:0] tx_nib = '0;
  logic       tx_sync = 1'b0;
  logic [9:0] tx_word;
  logic       tx_word_valid;
  logic [5:0] gain_word;
  logic [9:0] rx_word = '0;
  logic       rx_word_valid = 1'b0;
  logic       rx_word_ready;
  logic [5:0] rx_nib;
  logic       rx_sync;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nibif_top u_nibif_top (.*);

  // {first level, offset binary, word}
  localparam logic [11:0] VEC [8] = '{
    {1'b1, 1'b0, 10'h000}, {1'b1, 1'b0, 10'h3FF}, {1'b1, 1'b1, 10'h200},
    {1'b0, 1'b0, 10'h155}, {1'b0, 1'b1, 10'h2AA}, {1'b1, 1'b1, 10'h1E3},
    {1'b0, 1'b0, 10'h21F}, {1'b0, 1'b1, 10'h0C6}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  function automatic logic [9:0] fmt(input logic [9:0] w, input logic ob);
    return {w[9] ^ ob, w[8:0]};
  endfunction

  // bus-format word w sent as two nibbles; bit 5 set to show it is ignored
  task automatic send_tx(input logic [9:0] w);
    tx_nib = {1'b1, w[9:5]}; tx_sync = cfg_first_lvl; tick;
    chk(!tx_word_valid, "R1 no early valid", 16'(tx_word_valid), 16'h0);
    tx_nib = {1'b1, w[4:0]}; tx_sync = ~cfg_first_lvl; tick;
    tx_nib = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R10 reset state
    chk(!tx_word_valid, "R10 valid", 16'(tx_word_valid), 16'h0);
    chk(rx_nib == 0 && rx_sync == 0, "R10 rx bus", {9'h0, rx_sync, rx_nib}, 16'h0);
    chk(gain_word == 0, "R10 gain", 16'(gain_word), 16'h0);
    chk(rx_word_ready, "R10 ready", 16'(rx_word_ready), 16'h1);
    rst_n = 1'b1; tx_sync = ~cfg_first_lvl; tick;

    for (int i = 0; i < 8; i++) begin
      logic [9:0] w;
      logic [9:0] b;
      cfg_first_lvl = VEC[i][11]; cfg_offset_bin = VEC[i][10]; w = VEC[i][9:0];
      tx_sync = ~cfg_first_lvl; tick;
      // R1 R2 R3 transmit rebuild
      send_tx(w);
      chk(tx_word_valid && tx_word == fmt(w, cfg_offset_bin), "R1 R2 R3 tx word",
          {5'h0, tx_word_valid, tx_word}, {6'h01, fmt(w, cfg_offset_bin)});
      tick;
      chk(!tx_word_valid, "R1 one-cycle pulse", 16'(tx_word_valid), 16'h0);
      // R4 R2 R3 receive framing
      b = fmt(w, cfg_offset_bin);
      rx_word = w; rx_word_valid = 1'b1;
      chk(rx_word_ready, "R5 ready idle", 16'(rx_word_ready), 16'h1);
      tick; rx_word_valid = 1'b0;
      chk(rx_nib == {1'b0, b[9:5]} && rx_sync == cfg_first_lvl, "R4 first nibble",
          {9'h0, rx_sync, rx_nib}, {9'h0, cfg_first_lvl, 1'b0, b[9:5]});
      chk(!rx_word_ready, "R5 busy", 16'(rx_word_ready), 16'h0);
      tick;
      chk(rx_nib == {1'b0, b[4:0]} && rx_sync == ~cfg_first_lvl, "R4 second nibble",
          {9'h0, rx_sync, rx_nib}, {9'h0, ~cfg_first_lvl, 1'b0, b[4:0]});
      tick;
      chk(rx_nib == 0 && rx_sync == ~cfg_first_lvl, "R6 idle",
          {9'h0, rx_sync, rx_nib}, {9'h0, ~cfg_first_lvl, 6'h0});
    end

    cfg_first_lvl = 1'b1; cfg_offset_bin = 1'b0; tx_sync = 1'b0; tick;
    // R7 stray second nibble
    tx_nib = 6'h1F; tx_sync = 1'b0; tick; tick;
    chk(!tx_word_valid, "R7 stray ignored", 16'(tx_word_valid), 16'h0);
    // R7 repeated first nibble replaces
    tx_nib = 6'h03; tx_sync = 1'b1; tick;
    tx_nib = 6'h11; tx_sync = 1'b1; tick;
    tx_nib = 6'h05; tx_sync = 1'b0; tick;
    chk(tx_word_valid && tx_word == 10'h225, "R7 replace", {5'h0, tx_word_valid, tx_word}, 16'h0625);
    tick;

    // R5 back-to-back receive words
    rx_word = 10'h3C1; rx_word_valid = 1'b1; tick;
    chk(!rx_word_ready, "R5 held off", 16'(rx_word_ready), 16'h0);
    rx_word = 10'h0A7; tick;
    chk(rx_word_ready, "R5 ready again", 16'(rx_word_ready), 16'h1);
    tick; rx_word_valid = 1'b0;
    chk(rx_nib == {1'b0, 5'h05} && rx_sync == 1'b1, "R5 R4 second word first nibble",
        {9'h0, rx_sync, rx_nib}, 16'h0045);
    tick; tick;

    // R8 loopback
    cfg_loopback = 1'b1; tx_nib = 6'h2A; tx_sync = 1'b1; tick;
    chk(rx_nib == 6'h2A && rx_sync == 1'b1, "R8 echo", {9'h0, rx_sync, rx_nib}, 16'h006A);
    chk(!rx_word_ready, "R5 loop not ready", 16'(rx_word_ready), 16'h0);
    tx_nib = 6'h15; tx_sync = 1'b0; tick;
    chk(rx_nib == 6'h15 && rx_sync == 1'b0, "R8 echo 2", {9'h0, rx_sync, rx_nib}, 16'h0015);
    cfg_loopback = 1'b0; tx_nib = '0; tick; tick;

    // R9 gain mode
    cfg_gain_mode = 1'b1; tx_nib = 6'h35; tx_sync = 1'b1; tick;
    chk(gain_word == 6'h35, "R9 gain load", 16'(gain_word), 16'h35);
    tx_nib = 6'h0F; tx_sync = 1'b0; tick;
    chk(!tx_word_valid && gain_word == 6'h35, "R9 no word, gain kept",
        {9'h0, tx_word_valid, gain_word}, 16'h0035);
    cfg_gain_mode = 1'b0; tick;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule